// File: doc/BRIEF.md
# Guarded Snapshot Register Bank

This block is the register file and access controller that sits behind the byte-level front end of a serial-bus real-time clock. The front end has already decoded the bus protocol. It reports the start of a transaction together with a read/write flag, an address-load strobe, a written data byte, a request for a read byte, and the end of the transaction. The block keeps a byte pointer into a 56-byte address space, stores every section except the clock bytes, and gates writes to the clock bytes with a single enable bit in a control register. An accepted clock write is not stored here. It leaves as a one-cycle load strobe, with address and data, for the separate counter block that keeps time.

When a read transaction starts, the block copies the live clock bytes and the alarm bytes into a shadow buffer. Every read of those addresses within the transaction is served from that copy, so a multi-byte time read stays coherent even if the counter ticks mid-read. The pointer advances after every byte read or written. It wraps from the last mapped address to zero and keeps its value between transactions, which lets a read that loads no address carry on where the last access stopped.

A control FSM has three states. `ST_IDLE` means no transaction is open. `ST_WRITE` means a write transaction is open. `ST_READ` means a read transaction is open. The transitions are as follows:
- `IDLE->WRITE` / `IDLE->READ`: on a start, chosen by the read flag.
- `WRITE->IDLE` / `READ->IDLE`: on a stop.
- `WRITE/READ->WRITE/READ`: on a repeated start, which takes the new read flag. A repeated start into READ captures the shadow again.

Top module: `snapreg_bank`

## Requirements
- R1: After reset the pointer is 00h, every stored byte is 00h (so the clock write-enable bit, bit 6 of address 0Ch, is 0), and `rd_vld` and `clk_ld_vld` are low.
- R2: Bytes written to any address from 08h to 37h read back unchanged in a later read transaction.
- R3: A byte written to 00h–07h while bit 6 of 0Ch is 0 raises no load strobe. The pointer still advances past it.
- R4: A byte written to 00h–07h while bit 6 of 0Ch is 1 raises `clk_ld_vld` for exactly the cycle after the data byte is taken. During that cycle `clk_ld_addr` carries the low three address bits and `clk_ld_data` carries the byte.
- R5: Within a transaction the pointer increments after every byte read or written, and a burst may run across section boundaries.
- R6: A read of 00h–07h or 1Dh–28h returns the value those bytes had at the start of the current read transaction, even if the live clock input changes later in that transaction.
- R7: A read request made in a read transaction returns, on `rd_data` with `rd_vld` high in the following cycle, the byte at the pointer. Requests made outside a read transaction are ignored.
- R8: The pointer keeps its value across a stop. A read that loads no address continues at the last accessed address plus one.
- R9: An access at 37h moves the pointer to 00h.
- R10: Reads of 38h–FFh return 00h, writes there change nothing, and an access there moves the pointer to 00h.
- R11: The shadow is refreshed at every read start, including a repeated start. A new read therefore sees clock and alarm values updated since the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start (or repeated start) of a transaction |
| bus_rd | input | 1 | Read flag, sampled with `bus_start` (1 = read) |
| bus_addr_vld | input | 1 | Load `bus_addr` into the pointer |
| bus_addr | input | 8 | Register address |
| bus_wr_vld | input | 1 | Data byte available for writing |
| bus_wr_data | input | 8 | Data byte to write |
| bus_rd_req | input | 1 | Request the next read byte |
| bus_stop | input | 1 | End of transaction |
| live_time | input | 64 | Live clock bytes from the counter; byte k sits at bits 8k+7:8k |
| rd_vld | output | 1 | `rd_data` holds a requested byte |
| rd_data | output | 8 | Read byte |
| clk_ld_vld | output | 1 | One-cycle strobe for an accepted clock write |
| clk_ld_addr | output | 3 | Clock byte index for the strobe |
| clk_ld_data | output | 8 | Clock byte value for the strobe |

## Verification
A pointer that is off by one shows up as a wrong `rd_data` on the very next read byte. Because the pointer persists, the error also carries into later transactions that load no address. A stale or missed shadow capture shows up only in reads of the clock or alarm bytes, and only after the live input has changed, so the bench changes the live time both inside and between read transactions. A wrong protect decision shows up in the cycle after the data byte, as a missing or unexpected load strobe.

// File: rtl/snapreg_pkg.sv
`timescale 1ns/1ps
package snapreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } txn_state_e;

endpackage

// File: rtl/snapreg_ctrl.sv
`timescale 1ns/1ps
module snapreg_ctrl
    import snapreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rd_flag,
    input  logic       stop,
    input  logic       addr_vld,
    input  logic       wr_vld,
    input  logic       rd_req,
    output txn_state_e state,
    output logic       capture,
    output logic       load,
    output logic       do_wr,
    output logic       do_rd,
    output logic       adv
);

    txn_state_e state_q;
    txn_state_e state_d;
    logic       quiet;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision: a start always wins, a stop closes any open transaction
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = rd_flag ? ST_READ : ST_WRITE;
                end
            end
            ST_WRITE, ST_READ: begin
                if (start) begin
                    state_d = rd_flag ? ST_READ : ST_WRITE;
                end else if (stop) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // per-cycle actions from the current state
    always_comb begin
        quiet   = !start && !stop;
        capture = start && rd_flag;
        load    = 1'b0;
        do_wr   = 1'b0;
        do_rd   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = 1'b0;
            end
            ST_WRITE: begin
                load  = quiet && addr_vld;
                do_wr = quiet && !addr_vld && wr_vld;
            end
            ST_READ: begin
                load  = quiet && addr_vld;
                do_rd = quiet && !addr_vld && rd_req;
            end
            default: begin
                load = 1'b0;
            end
        endcase
        adv = do_wr || do_rd;
    end

    assign state = state_q;

endmodule

// File: rtl/snapreg_ptr.sv
`timescale 1ns/1ps
module snapreg_ptr #(
    parameter int AW   = 8,
    parameter int LAST = 8'h37
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          adv,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST_A = AW'(LAST);

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_addr;
        end else if (adv) begin
            // the last mapped address and everything above it fold back to zero
            ptr_q <= (ptr_q >= LAST_A) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/snapreg_store.sv
`timescale 1ns/1ps
module snapreg_store #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int BASE     = 8,
    parameter int N        = 48,
    parameter int CTRL_A   = 8'h0C,
    parameter int WEN_BIT  = 6,
    parameter int ALM_BASE = 8'h1D,
    parameter int ALM_N    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [DW-1:0]       wdata,
    input  logic [AW-1:0]       raddr,
    output logic [DW-1:0]       rdata,
    output logic                wen_flag,
    output logic [ALM_N*DW-1:0] alm_flat
);

    localparam int CTRL_IDX = CTRL_A - BASE;
    localparam int ALM_IDX  = ALM_BASE - BASE;

    logic [DW-1:0] mem_q [N];

    for (genvar i = 0; i < N; i++) begin : g_byte
        localparam logic [AW-1:0] MY_A = AW'(BASE + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (we && (waddr == MY_A)) begin
                mem_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (raddr == AW'(BASE + i)) begin
                rdata = mem_q[i];
            end
        end
    end

    for (genvar j = 0; j < ALM_N; j++) begin : g_alm
        assign alm_flat[j*DW +: DW] = mem_q[ALM_IDX + j];
    end

    assign wen_flag = mem_q[CTRL_IDX][WEN_BIT];

endmodule

// File: rtl/snapreg_shadow.sv
`timescale 1ns/1ps
module snapreg_shadow #(
    parameter int DW    = 8,
    parameter int CLK_N = 8,
    parameter int ALM_N = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [CLK_N*DW-1:0] live_clk,
    input  logic [ALM_N*DW-1:0] live_alm,
    output logic [CLK_N*DW-1:0] snap_clk,
    output logic [ALM_N*DW-1:0] snap_alm
);

    logic [CLK_N*DW-1:0] clk_q;
    logic [ALM_N*DW-1:0] alm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= '0;
            alm_q <= '0;
        end else if (capture) begin
            clk_q <= live_clk;
            alm_q <= live_alm;
        end
    end

    assign snap_clk = clk_q;
    assign snap_alm = alm_q;

endmodule

// File: rtl/snapreg_bank.sv
`timescale 1ns/1ps
module snapreg_bank
    import snapreg_pkg::*;
#(
    parameter int  AW       = 8,
    parameter int  DW       = 8,
    parameter int  CLK_N    = 8,
    parameter int  ALM_BASE = 8'h1D,
    parameter int  ALM_N    = 12,
    parameter int  LAST     = 8'h37,
    parameter int  CTRL_A   = 8'h0C,
    parameter int  WEN_BIT  = 6,
    localparam int CLK_AW   = $clog2(CLK_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_start,
    input  logic                bus_rd,
    input  logic                bus_addr_vld,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_wr_vld,
    input  logic [DW-1:0]       bus_wr_data,
    input  logic                bus_rd_req,
    input  logic                bus_stop,
    input  logic [CLK_N*DW-1:0] live_time,
    output logic                rd_vld,
    output logic [DW-1:0]       rd_data,
    output logic                clk_ld_vld,
    output logic [CLK_AW-1:0]   clk_ld_addr,
    output logic [DW-1:0]       clk_ld_data
);

    localparam int            STORE_N = LAST - CLK_N + 1;
    localparam logic [AW-1:0] CLK_END = AW'(CLK_N);
    localparam logic [AW-1:0] LAST_A  = AW'(LAST);
    localparam logic [AW-1:0] ALM_LO  = AW'(ALM_BASE);
    localparam logic [AW-1:0] ALM_HI  = AW'(ALM_BASE + ALM_N - 1);

    txn_state_e            st_q;
    logic                  capture;
    logic                  load;
    logic                  do_wr;
    logic                  do_rd;
    logic                  adv;
    logic [AW-1:0]         ptr_q;
    logic                  in_clk;
    logic                  in_store;
    logic                  in_alm;
    logic                  store_we;
    logic [DW-1:0]         store_rdata;
    logic                  wen_flag;
    logic [ALM_N*DW-1:0]   alm_flat;
    logic [CLK_N*DW-1:0]   snap_clk;
    logic [ALM_N*DW-1:0]   snap_alm;
    logic [DW-1:0]         rd_byte;
    logic                  rd_vld_q;
    logic [DW-1:0]         rd_data_q;
    logic                  ld_vld_q;
    logic [CLK_AW-1:0]     ld_addr_q;
    logic [DW-1:0]         ld_data_q;

    snapreg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (bus_start),
        .rd_flag  (bus_rd),
        .stop     (bus_stop),
        .addr_vld (bus_addr_vld),
        .wr_vld   (bus_wr_vld),
        .rd_req   (bus_rd_req),
        .state    (st_q),
        .capture  (capture),
        .load     (load),
        .do_wr    (do_wr),
        .do_rd    (do_rd),
        .adv      (adv)
    );

    snapreg_ptr #(.AW(AW), .LAST(LAST)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (bus_addr),
        .adv       (adv),
        .ptr       (ptr_q)
    );

    // address decode of the pointer
    assign in_clk   = (ptr_q < CLK_END);
    assign in_store = (ptr_q >= CLK_END) && (ptr_q <= LAST_A);
    assign in_alm   = (ptr_q >= ALM_LO) && (ptr_q <= ALM_HI);
    assign store_we = do_wr && in_store;

    snapreg_store #(
        .AW(AW), .DW(DW), .BASE(CLK_N), .N(STORE_N), .CTRL_A(CTRL_A),
        .WEN_BIT(WEN_BIT), .ALM_BASE(ALM_BASE), .ALM_N(ALM_N)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (store_we),
        .waddr    (ptr_q),
        .wdata    (bus_wr_data),
        .raddr    (ptr_q),
        .rdata    (store_rdata),
        .wen_flag (wen_flag),
        .alm_flat (alm_flat)
    );

    snapreg_shadow #(.DW(DW), .CLK_N(CLK_N), .ALM_N(ALM_N)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .live_clk (live_time),
        .live_alm (alm_flat),
        .snap_clk (snap_clk),
        .snap_alm (snap_alm)
    );

    // read source selection: snapshot for clock and alarm, store elsewhere, zero off the map
    always_comb begin
        rd_byte = '0;
        if (in_clk) begin
            for (int k = 0; k < CLK_N; k++) begin
                if (ptr_q == AW'(k)) begin
                    rd_byte = snap_clk[k*DW +: DW];
                end
            end
        end else if (in_alm) begin
            for (int k = 0; k < ALM_N; k++) begin
                if (ptr_q == AW'(ALM_BASE + k)) begin
                    rd_byte = snap_alm[k*DW +: DW];
                end
            end
        end else if (in_store) begin
            rd_byte = store_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_data_q <= '0;
        end else begin
            rd_vld_q <= do_rd;
            if (do_rd) begin
                rd_data_q <= rd_byte;
            end
        end
    end

    // clock write path toward the counter block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_vld_q  <= 1'b0;
            ld_addr_q <= '0;
            ld_data_q <= '0;
        end else begin
            ld_vld_q <= do_wr && in_clk && wen_flag;
            if (do_wr && in_clk) begin
                ld_addr_q <= ptr_q[CLK_AW-1:0];
                ld_data_q <= bus_wr_data;
            end
        end
    end

    assign rd_vld      = rd_vld_q;
    assign rd_data     = rd_data_q;
    assign clk_ld_vld  = ld_vld_q;
    assign clk_ld_addr = ld_addr_q;
    assign clk_ld_data = ld_data_q;

endmodule

// File: rtl/snapreg_bank_chk.sv
`timescale 1ns/1ps
module snapreg_bank_chk #(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int CLK_N = 8,
    parameter int LAST  = 8'h37
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr_vld,
    input logic          bus_rd_req,
    input logic          rd_vld,
    input logic [DW-1:0] rd_data,
    input logic          clk_ld_vld,
    input logic [AW-1:0] ptr_q,
    input logic          adv,
    input logic [1:0]    st,
    input logic          wen
);

    localparam logic [1:0]    S_WRITE = 2'd1;
    localparam logic [1:0]    S_READ  = 2'd2;
    localparam logic [AW-1:0] LAST_A  = AW'(LAST);
    localparam logic [AW-1:0] CLK_END = AW'(CLK_N);

    assert_ld_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ld_vld |-> ($past(wen) && $past(bus_wr_vld)));

    assert_protect_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (st == S_WRITE) && (ptr_q < CLK_END) && !wen) |=> !clk_ld_vld);

    assert_rdvld_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> ($past(bus_rd_req) && ($past(st) == S_READ)));

    assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (ptr_q == LAST_A)) |=> (ptr_q == '0));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (ptr_q < LAST_A)) |=> (ptr_q == $past(ptr_q) + 1'b1));

    assert_offmap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && ($past(ptr_q) > LAST_A)) |-> (rd_data == '0));

endmodule

bind snapreg_bank snapreg_bank_chk #(
    .AW(AW), .DW(DW), .CLK_N(CLK_N), .LAST(LAST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_vld (bus_wr_vld),
    .bus_rd_req (bus_rd_req),
    .rd_vld     (rd_vld),
    .rd_data    (rd_data),
    .clk_ld_vld (clk_ld_vld),
    .ptr_q      (ptr_q),
    .adv        (adv),
    .st         (st_q),
    .wen        (wen_flag)
);

// File: tb/snapreg_bank_tb.sv
`timescale 1ns/1ps
module snapreg_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_addr_vld = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_vld = 1'b0;
    logic [7:0]  bus_wr_data = '0;
    logic        bus_rd_req = 1'b0;
    logic        bus_stop = 1'b0;
    logic [63:0] live_time = 64'h0;
    logic        rd_vld;
    logic [7:0]  rd_data;
    logic        clk_ld_vld;
    logic [2:0]  clk_ld_addr;
    logic [7:0]  clk_ld_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0]  mem_m [256];
    logic [7:0]  ptr_m = 8'h00;
    logic [63:0] snap_m = 64'h0;

    always #5 clk = ~clk;

    snapreg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rd(bus_rd),
        .bus_addr_vld(bus_addr_vld), .bus_addr(bus_addr), .bus_wr_vld(bus_wr_vld),
        .bus_wr_data(bus_wr_data), .bus_rd_req(bus_rd_req), .bus_stop(bus_stop),
        .live_time(live_time), .rd_vld(rd_vld), .rd_data(rd_data),
        .clk_ld_vld(clk_ld_vld), .clk_ld_addr(clk_ld_addr), .clk_ld_data(clk_ld_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (ptr model %0h)", req, act, exp, ptr_m);
        end
    endtask

    function automatic logic [7:0] exp_byte(logic [7:0] a);
        if (a < 8'h08) return snap_m[a[2:0]*8 +: 8];
        if (a <= 8'h37) return mem_m[a];
        return 8'h00;
    endfunction

    function automatic logic [7:0] next_ptr(logic [7:0] a);
        return (a >= 8'h37) ? 8'h00 : a + 8'h01;
    endfunction

    task automatic start_tx(logic rd);
        @(negedge clk);
        bus_start = 1'b1;
        bus_rd = rd;
        if (rd) snap_m = live_time;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    task automatic stop_tx();
        @(negedge clk);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
    endtask

    task automatic set_addr(logic [7:0] a);
        @(negedge clk);
        bus_addr_vld = 1'b1;
        bus_addr = a;
        ptr_m = a;
        @(negedge clk);
        bus_addr_vld = 1'b0;
    endtask

    task automatic wr_byte(string req, logic [7:0] d);
        logic en;
        en = mem_m[8'h0C][6];
        @(negedge clk);
        bus_wr_vld = 1'b1;
        bus_wr_data = d;
        @(negedge clk);
        bus_wr_vld = 1'b0;
        if (ptr_m < 8'h08 && en) begin
            check(req, {31'b0, clk_ld_vld}, 32'd1);
            check(req, {29'b0, clk_ld_addr}, {29'b0, ptr_m[2:0]});
            check(req, {24'b0, clk_ld_data}, {24'b0, d});
        end else begin
            check(req, {31'b0, clk_ld_vld}, 32'd0);
        end
        if (ptr_m >= 8'h08 && ptr_m <= 8'h37) mem_m[ptr_m] = d;
        ptr_m = next_ptr(ptr_m);
    endtask

    task automatic rd_byte(string req);
        @(negedge clk);
        bus_rd_req = 1'b1;
        @(negedge clk);
        bus_rd_req = 1'b0;
        check(req, {31'b0, rd_vld}, 32'd1);
        check(req, {24'b0, rd_data}, {24'b0, exp_byte(ptr_m)});
        ptr_m = next_ptr(ptr_m);
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) & 8'hBF);
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        live_time = 64'h8877_6655_4433_2211;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        check("R1", {31'b0, rd_vld}, 32'd0);
        check("R1", {31'b0, clk_ld_vld}, 32'd0);
        start_tx(1'b1);
        rd_byte("R1");            // pointer at 00h after reset
        set_addr(8'h0C);
        rd_byte("R1");            // control byte cleared
        stop_tx();

        // R7: read request outside a read transaction is ignored
        @(negedge clk); bus_rd_req = 1'b1;
        @(negedge clk); bus_rd_req = 1'b0;
        check("R7", {31'b0, rd_vld}, 32'd0);

        // R2 R5: burst write across every stored section, then burst read back
        start_tx(1'b0);
        set_addr(8'h08);
        for (int a = 8'h08; a <= 8'h37; a++) wr_byte("R5", pat(a));
        stop_tx();
        start_tx(1'b1);
        set_addr(8'h08);
        for (int a = 8'h08; a <= 8'h37; a++) rd_byte("R2");
        rd_byte("R9");            // wrapped to clock byte 00h
        stop_tx();

        // R8: pointer persists across stop
        start_tx(1'b1);
        rd_byte("R8");
        stop_tx();

        // R3: protected clock writes, pointer still moves
        start_tx(1'b0);
        set_addr(8'h0C);
        wr_byte("R3", 8'h00);
        set_addr(8'h00);
        for (int k = 0; k < 8; k++) wr_byte("R3", 8'hC0 + 8'(k));
        stop_tx();
        start_tx(1'b1);
        rd_byte("R3");            // continues at 08h
        stop_tx();

        // R4: enabled clock writes raise strobes
        start_tx(1'b0);
        set_addr(8'h0C);
        wr_byte("R4", 8'h40);
        set_addr(8'h00);
        for (int k = 0; k < 8; k++) wr_byte("R4", 8'h90 ^ 8'(k * 5));
        stop_tx();

        // R9: wrap during a write burst into a strobed clock byte
        start_tx(1'b0);
        set_addr(8'h37);
        wr_byte("R9", 8'hA5);
        wr_byte("R9", 8'h3C);
        stop_tx();

        // R6: snapshot holds while the live time moves
        live_time = 64'h0102_0304_0506_0708;
        start_tx(1'b1);
        set_addr(8'h00);
        live_time = 64'hF0E0_D0C0_B0A0_9080;
        for (int a = 0; a <= 8'h28; a++) rd_byte("R6");
        stop_tx();

        // R11: a new read start and a repeated start both refresh
        start_tx(1'b1);
        set_addr(8'h00);
        for (int k = 0; k < 8; k++) rd_byte("R11");
        live_time = 64'h1357_9BDF_2468_ACE0;
        start_tx(1'b1);
        set_addr(8'h03);
        rd_byte("R11");
        stop_tx();

        // R11: alarm bytes updated by a write are seen by the next read
        start_tx(1'b0);
        set_addr(8'h1D);
        for (int k = 0; k < 12; k++) wr_byte("R11", 8'h5A + 8'(k * 9));
        stop_tx();
        start_tx(1'b1);
        set_addr(8'h1D);
        for (int k = 0; k < 12; k++) rd_byte("R11");
        stop_tx();

        // R10: off-map writes ignored, reads zero, pointer folds to 00h
        start_tx(1'b0);
        set_addr(8'h40);
        wr_byte("R10", 8'hEE);
        set_addr(8'hFE);
        wr_byte("R10", 8'hDD);
        stop_tx();
        start_tx(1'b1);
        rd_byte("R10");           // pointer folded to 00h after the FEh write
        set_addr(8'h38);
        rd_byte("R10");
        rd_byte("R10");           // folded to 00h
        for (int a = 0; a < 256; a++) begin
            set_addr(8'(a));
            rd_byte("R10");       // full map sweep, stored bytes unchanged
        end
        stop_tx();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule